// File: doc/BRIEF.md
# HDLC Receive Bit-Clock Recovery Loop

This block rebuilds a receive bit clock from nothing but the serial data line, so a link needs no separate clock wire. It runs in the system clock domain and is paced by a reference enable that pulses at sixteen times the nominal bit rate. A free-running phase counter divides that reference by sixteen. Each accepted level change on the line is treated as the start of a bit cell and nudges the counter's phase, so the recovered clock falls in the middle of every cell. At that falling edge the filtered line level is delivered as a received bit together with a one-cycle strobe.

Before any phase decision, the line passes through a synchronizer and a three-sample majority vote at the reference rate, so a one-sample spike is not taken for a cell boundary. Once the loop is tracking, it corrects by at most one reference step per edge, which rides out jitter. After reset, or after a long silence on the line, the first edge snaps the phase directly. The line is assumed to carry enough transitions, as the upstream encoding and bit stuffing provide. A transmit-clock enable is also produced. It comes either from a plain divide-by-sixteen of the reference or from the recovered clock.

Top module: `hdlc_clk_recovery`

## Requirements
- R1: While `rst` is high and before any reference enable follows it, `rec_clk` is 1 and `rx_bit_valid` and `tx_clk_en` are 0.
- R2: With `tx_sel` = 0, `tx_clk_en` is a one-cycle pulse that repeats once every 16 reference enables, whatever the data line does.
- R3: No internal state moves on a clock edge where `ref_en` is 0. With `ref_en` held low, no strobes appear and `rec_clk` holds its level. With `ref_en` high every other cycle, every period doubles.
- R4: A level change on `rx_data` that lasts a single reference sample is rejected. It causes no phase correction and does not alter the received bit.
- R5: With the loop tracking and `ref_en` high every cycle, each 16-cycle bit cell gives exactly one `rx_bit_valid` pulse, in the same cycle that `rec_clk` falls. The pulse starts at the 11th rising clock edge at which the cell's level is present on `rx_data`, and `rx_bit` then equals that level.
- R6: `rec_clk` is high for 8 reference enables and low for the following 8 when no corrections occur.
- R7: Bit cells that are all one reference step longer (17) or all one step shorter (15) than nominal, with a transition at every cell, keep the strobe at the same position in each cell as in R5.
- R8: With the loop tracking, a single phase slip that makes the line 4 steps late is corrected one step per edge. The strobe positions in the following cells, counted as in R5, are 8, 9, 10, 11 and 11.
- R9: With the loop tracking, a slip that makes the line 4 steps early is corrected one step per edge. The strobe positions in the following cells are 14, 13, 12, 11 and 11.
- R10: The first accepted edge after reset, or after more than 32 bit times (512 reference enables) with no accepted edge, sets the phase in one step, and that cell's last strobe is at position 11. An edge that comes before that limit is corrected by a single step only.
- R11: With `tx_sel` = 1, `tx_clk_en` pulses in the cycle where `rec_clk` rises. That is once per bit cell, at the 3rd rising edge at which the cell's level is present on a tracked line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_en | input | 1 | Reference enable at 16 times the bit rate |
| rx_data | input | 1 | Serial receive data, asynchronous to clk |
| tx_sel | input | 1 | Transmit clock source: 0 fixed divider, 1 recovered clock |
| rx_bit | output | 1 | Received bit, sampled at mid-cell |
| rx_bit_valid | output | 1 | One-cycle strobe marking a new rx_bit |
| rec_clk | output | 1 | Recovered receive clock level |
| tx_clk_en | output | 1 | One-cycle transmit clock enable from the selected source |

## Verification
The hardest behaviour to reach from the ports is the separation between a single-step correction and a full phase reload. It depends on how long the line has been quiet, which lies hundreds of reference steps in the past. The bench holds the line constant for a count of cells just under the silence limit and then just over it. It ends each hold with a cell stretched by four steps, so the same phase slip appears in both cases. It then checks that only the second case lands the strobe at mid-cell at once. Stretched and shortened single cells produce the exact one-step-per-edge convergence sequences in both directions.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    // Filtered view of the receive line at one reference step
    typedef struct packed {
        logic level;      // majority-voted line level
        logic edge_seen;  // accepted transition in this step
    } rx_sense_t;

    // Phase decision taken on a reference step
    typedef enum logic [1:0] {
        PH_NORMAL  = 2'd0,
        PH_RETARD  = 2'd1,
        PH_ADVANCE = 2'd2,
        PH_LOAD    = 2'd3
    } ph_step_t;

    // Mid-cell sample handed to the output
    typedef struct packed {
        logic valid;
        logic bit_val;
    } sample_t;

    // Majority of the lowest n bits of taps (n odd, at most 8)
    function automatic logic vote(input logic [7:0] taps, input int n);
        int ones;
        ones = 0;
        for (int i = 0; i < 8; i++) begin
            if (i < n && taps[i]) ones++;
        end
        return (ones > n / 2);
    endfunction

endpackage

// File: rtl/rxd_filter.sv
module rxd_filter
    import dpll_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_TAPS   = 3,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx_in,
    output rx_sense_t sense
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_TAPS-2:0]   win_q;
    logic                   lvl_q;
    logic                   line;
    logic [FILT_TAPS-1:0]   taps;
    logic [7:0]             taps8;
    logic                   voted;

    // Synchronizer chain, length chosen by parameter
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= IDLE_LEVEL;
                else     sync_q[0] <= rx_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= IDLE_LEVEL;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign line = sync_q[SYNC_STAGES-1];
    assign taps = {win_q, line};

    always_comb begin
        taps8 = '0;
        taps8[FILT_TAPS-1:0] = taps;
        voted = vote(taps8, FILT_TAPS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= {(FILT_TAPS-1){IDLE_LEVEL}};
            lvl_q <= IDLE_LEVEL;
        end else if (tick) begin
            win_q <= taps[FILT_TAPS-2:0];
            lvl_q <= voted;
        end
    end

    always_comb begin
        sense.level     = voted;
        sense.edge_seen = tick && (voted != lvl_q);
    end

endmodule

// File: rtl/phase_tracker.sv
module phase_tracker
    import dpll_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int IDLE_BITS  = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  rx_sense_t sense,
    output logic      rec_clk,
    output sample_t   smp,
    output logic      wrap_pulse
);

    localparam int CW         = $clog2(OVERSAMPLE);
    localparam int HALF       = OVERSAMPLE / 2;
    localparam int IDLE_LIMIT = IDLE_BITS * OVERSAMPLE;
    localparam int IW         = $clog2(IDLE_LIMIT + 1);

    logic [CW-1:0] cnt_q, cnt_nx;
    logic [IW-1:0] idle_q;
    logic          locked_q;
    ph_step_t      step;

    // Choose the phase action for this reference step
    always_comb begin
        if (!sense.edge_seen)                       step = PH_NORMAL;
        else if (!locked_q)                         step = PH_LOAD;
        else if (cnt_q == '0 || cnt_q == CW'(HALF)) step = PH_NORMAL;
        else if (cnt_q < CW'(HALF))                 step = PH_RETARD;
        else                                        step = PH_ADVANCE;
    end

    always_comb begin
        cnt_nx = cnt_q;
        if (tick) begin
            case (step)
                PH_LOAD:    cnt_nx = CW'(1);
                PH_RETARD:  cnt_nx = cnt_q;
                PH_ADVANCE: cnt_nx = cnt_q + CW'(2);
                default:    cnt_nx = cnt_q + CW'(1);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nx;
        end
    end

    // Silence timer: drops the loop back to fast acquisition
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q   <= '0;
            locked_q <= 1'b0;
        end else if (tick) begin
            if (sense.edge_seen) begin
                idle_q   <= '0;
                locked_q <= 1'b1;
            end else if (idle_q != IW'(IDLE_LIMIT)) begin
                idle_q <= idle_q + IW'(1);
            end else begin
                locked_q <= 1'b0;
            end
        end
    end

    // Sample on the falling edge of the recovered clock, wrap on rising
    always_ff @(posedge clk) begin
        if (rst) begin
            smp        <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            smp.valid  <= tick && !cnt_q[CW-1] && cnt_nx[CW-1];
            if (tick && !cnt_q[CW-1] && cnt_nx[CW-1]) smp.bit_val <= sense.level;
            wrap_pulse <= tick && cnt_q[CW-1] && !cnt_nx[CW-1];
        end
    end

    assign rec_clk = !cnt_q[CW-1];

endmodule

// File: rtl/txclk_select.sv
module txclk_select #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic use_rec,
    input  logic rec_wrap,
    output logic tx_pulse
);

    localparam int CW = $clog2(OVERSAMPLE);

    logic [CW-1:0] div_q;
    logic          div_pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q       <= '0;
            div_pulse_q <= 1'b0;
        end else begin
            div_pulse_q <= tick && (div_q == CW'(OVERSAMPLE - 1));
            if (tick) div_q <= div_q + CW'(1);
        end
    end

    assign tx_pulse = use_rec ? rec_wrap : div_pulse_q;

endmodule

// File: rtl/hdlc_clk_recovery.sv
module hdlc_clk_recovery
    import dpll_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int IDLE_BITS   = 32,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_en,
    input  logic rx_data,
    input  logic tx_sel,
    output logic rx_bit,
    output logic rx_bit_valid,
    output logic rec_clk,
    output logic tx_clk_en
);

    rx_sense_t sense;
    sample_t   smp;
    logic      wrap;

    rxd_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_TAPS  (FILT_TAPS),
        .IDLE_LEVEL (1'b1)
    ) u_filter (
        .clk  (clk),
        .rst  (rst),
        .tick (ref_en),
        .rx_in(rx_data),
        .sense(sense)
    );

    phase_tracker #(
        .OVERSAMPLE(OVERSAMPLE),
        .IDLE_BITS (IDLE_BITS)
    ) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .tick      (ref_en),
        .sense     (sense),
        .rec_clk   (rec_clk),
        .smp       (smp),
        .wrap_pulse(wrap)
    );

    txclk_select #(
        .OVERSAMPLE(OVERSAMPLE)
    ) u_txsel (
        .clk     (clk),
        .rst     (rst),
        .tick    (ref_en),
        .use_rec (tx_sel),
        .rec_wrap(wrap),
        .tx_pulse(tx_clk_en)
    );

    assign rx_bit       = smp.bit_val;
    assign rx_bit_valid = smp.valid;

endmodule

// File: rtl/hdlc_clk_recovery_chk.sv
module hdlc_clk_recovery_chk (
    input logic clk,
    input logic rst,
    input logic ref_en,
    input logic tx_sel,
    input logic rx_bit_valid,
    input logic rec_clk,
    input logic tx_clk_en
);

    // R5: the sample strobe lasts one cycle
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rx_bit_valid |=> !rx_bit_valid);

    // R5: the sample strobe coincides with the falling recovered clock
    p_valid_at_fall_r5: assert property (@(posedge clk) disable iff (rst)
        rx_bit_valid |-> (!rec_clk && $past(rec_clk)));

    // R2: the transmit enable lasts one cycle
    p_tx_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        tx_clk_en |=> !tx_clk_en);

    // R3: nothing moves on an edge without a reference enable
    p_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
        !ref_en |=> ($stable(rec_clk) && !rx_bit_valid && !tx_clk_en));

    // R11: recovered transmit enable coincides with the rising recovered clock
    p_rec_tx_rise_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_sel && tx_clk_en) |-> (rec_clk && !$past(rec_clk)));

endmodule

bind hdlc_clk_recovery hdlc_clk_recovery_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_en      (ref_en),
    .tx_sel      (tx_sel),
    .rx_bit_valid(rx_bit_valid),
    .rec_clk     (rec_clk),
    .tx_clk_en   (tx_clk_en)
);

// File: tb/test_hdlc_clk_recovery.sv
module test_hdlc_clk_recovery;

    logic clk = 1'b0;
    logic rst, ref_en, rx_data, tx_sel;
    logic rx_bit, rx_bit_valid, rec_clk, tx_clk_en;

    always #4 clk = ~clk;

    hdlc_clk_recovery i_hdlc_clk_recovery (
        .clk         (clk),
        .rst         (rst),
        .ref_en      (ref_en),
        .rx_data     (rx_data),
        .tx_sel      (tx_sel),
        .rx_bit      (rx_bit),
        .rx_bit_valid(rx_bit_valid),
        .rec_clk     (rec_clk),
        .tx_clk_en   (tx_clk_en)
    );

    int   checks = 0;
    int   errors = 0;
    int   vcnt, voff, tcnt, toff;
    logic vbit;
    logic lastbit;
    bit   finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one bit cell of len cycles, recording strobes by offset in the cell
    task automatic send_cell(input logic d, input int len, input int glitch);
        vcnt = 0; voff = -1; vbit = 1'b0; tcnt = 0; toff = -1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (rx_bit_valid) begin vcnt++; voff = i; vbit = rx_bit; end
            if (tx_clk_en) begin tcnt++; toff = i; end
            rx_data = (i == glitch) ? ~d : d;
        end
        lastbit = d;
    endtask

    task automatic cell_chk(input logic d, input int len, input int glitch,
                            input int exp_off, input string req);
        send_cell(d, len, glitch);
        chk(vcnt == 1 && voff == exp_off && vbit == d, req, "count*1000+offset*10+bit",
            vcnt * 1000 + voff * 10 + int'(vbit), 1000 + exp_off * 10 + int'(d));
    endtask

    task automatic alt(input int n);
        for (int i = 0; i < n; i++) send_cell(~lastbit, 16, -1);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog run hung actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int last_t, t, n;
        bool_ok_init();
        rst = 1'b1; ref_en = 1'b1; rx_data = 1'b1; tx_sel = 1'b0; lastbit = 1'b1;
        repeat (4) @(negedge clk);
        ref_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        @(negedge clk);
        chk(rec_clk == 1'b1 && !rx_bit_valid && !tx_clk_en, "R1", "rec_clk,valid,tx",
            {rec_clk, rx_bit_valid, tx_clk_en}, 3'b100);

        // R3: no reference enables, line toggling
        n = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rx_bit_valid || tx_clk_en || !rec_clk) n++;
            rx_data = i[2];
        end
        chk(n == 0, "R3", "activity without ref_en", n, 0);
        rx_data = 1'b1;
        repeat (4) @(negedge clk);

        // R2: fixed divider, every cycle a reference step
        ref_en = 1'b1;
        last_t = -1; n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tx_clk_en) begin
                if (last_t >= 0) begin
                    chk(i - last_t == 16, "R2", "divider interval", i - last_t, 16);
                    n++;
                end
                last_t = i;
            end
        end
        chk(n >= 10, "R2", "divider pulses seen", n, 11);

        // R3: half-rate reference doubles the divider period; R6 recovered clock levels
        last_t = -1; n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (tx_clk_en) begin
                if (last_t >= 0) begin
                    chk(i - last_t == 32, "R3", "half-rate interval", i - last_t, 32);
                    n++;
                end
                last_t = i;
            end
            ref_en = ~ref_en;
        end
        chk(n >= 10, "R3", "half-rate pulses seen", n, 11);
        ref_en = 1'b1;
        @(negedge clk);
        n = 0; t = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (rec_clk) n++;
            if (i > 0 && rec_clk != 1'(t)) t = t; // no-op keeps level history simple
            t = int'(rec_clk);
        end
        chk(n == 32, "R6", "rec_clk high cycles in 64", n, 32);

        // R10 + R5: first edge after reset acquires, then an exhaustive byte sweep
        for (int b = 0; b < 256; b++) begin
            for (int k = 0; k < 8; k++) begin
                logic d;
                d = b[k];
                if (b == 0 && k == 0) begin
                    send_cell(d, 16, -1);
                    chk(voff == 11 && vbit == d, "R10", "acquire offset*10+bit",
                        voff * 10 + int'(vbit), 110 + int'(d));
                end else begin
                    cell_chk(d, 16, -1, 11, "R5");
                end
            end
        end

        // R7: slow and fast cells
        for (int i = 0; i < 30; i++) cell_chk(~lastbit, 17, -1, 11, "R7");
        alt(4);
        for (int i = 0; i < 30; i++) cell_chk(~lastbit, 15, -1, 11, "R7");
        alt(4);

        // R4: one-sample glitches inside held and toggling cells
        for (int i = 0; i < 4; i++) cell_chk(lastbit, 16, 6, 11, "R4");
        for (int i = 0; i < 6; i++) cell_chk(~lastbit, 16, 3 + i, 11, "R4");

        // R8: line slips 4 steps late
        alt(4);
        cell_chk(~lastbit, 20, -1, 11, "R8");
        cell_chk(~lastbit, 16, -1, 8, "R8");
        cell_chk(~lastbit, 16, -1, 9, "R8");
        cell_chk(~lastbit, 16, -1, 10, "R8");
        cell_chk(~lastbit, 16, -1, 11, "R8");
        cell_chk(~lastbit, 16, -1, 11, "R8");

        // R9: line slips 4 steps early
        alt(2);
        cell_chk(~lastbit, 12, -1, 11, "R9");
        cell_chk(~lastbit, 16, -1, 14, "R9");
        cell_chk(~lastbit, 16, -1, 13, "R9");
        cell_chk(~lastbit, 16, -1, 12, "R9");
        cell_chk(~lastbit, 16, -1, 11, "R9");
        cell_chk(~lastbit, 16, -1, 11, "R9");

        // R11: recovered transmit clock
        tx_sel = 1'b1;
        alt(2);
        for (int i = 0; i < 12; i++) begin
            send_cell((i % 4 == 3) ? lastbit : ~lastbit, 16, -1);
            chk(tcnt == 1 && toff == 3, "R11", "tx count*100+offset",
                tcnt * 100 + toff, 103);
        end
        tx_sel = 1'b0;

        // R10: silence just under the limit keeps single-step correction
        alt(3);
        for (int i = 0; i < 27; i++) send_cell(lastbit, 16, -1);
        send_cell(lastbit, 20, -1);
        cell_chk(~lastbit, 16, -1, 8, "R10");
        alt(6);
        // R10: silence past the limit re-acquires in one step
        for (int i = 0; i < 39; i++) send_cell(lastbit, 16, -1);
        send_cell(lastbit, 20, -1);
        send_cell(~lastbit, 16, -1);
        chk(voff == 11 && vbit == lastbit, "R10", "reacquire offset*10+bit",
            voff * 10 + int'(vbit), 110 + int'(lastbit));
        cell_chk(~lastbit, 16, -1, 11, "R10");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic bool_ok_init();
        vcnt = 0; voff = 0; tcnt = 0; toff = 0; vbit = 1'b0;
    endtask

endmodule